// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This block keeps the interrupt state of an I2C master controller. The bus engine and the FIFO logic feed it single-cycle event pulses, the current TX and RX FIFO fill levels, a bus-busy level and an abort cause vector. From these it builds a 12-bit raw status word. The raw word is ANDed with a writable mask to give the masked status, and the OR of the masked word drives one combined interrupt line.

Some status bits are levels derived from FIFO fill against programmable thresholds. The others are sticky: they are set by events and cleared when software reads a dedicated clear address. After a transmit abort, the block holds the TX FIFO flushed and keeps the abort cause until software acknowledges the abort.

Clearing is done with a single-cycle read strobe plus an address. One cycle after the strobe, the block returns the value the addressed bit held before the clear. No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control and status pins, sampled on the rising clock edge. Reset is asynchronous and active low.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: Status bit positions are: RX underflow 0, RX overflow 1, RX threshold 2, TX overflow 3, TX threshold 4, abort 6, activity 8, stop seen 9, start seen 10, general call 11. Bits 5, 7 and 12 upward do not exist in the word and read 0. A sticky bit shows in `raw_stat` on the cycle after its event pulse.
- R2: The mask resets to 0x8FF. A `mask_wr` pulse loads `mask_wdata` on the next edge. `masked_stat` always equals `raw_stat` AND mask.
- R3: `irq` is high exactly when `masked_stat` is nonzero.
- R4: Bit 4 is high while `tx_level` is at or below the effective TX threshold. No read clears it.
- R5: Bit 2 is high while `rx_level` is at or above the effective RX threshold plus one. No read clears it.
- R6: An effective threshold equals the written threshold when that value is 0 to 15. Any larger written value acts as 15 and appears as 15 on the `*_thr_eff` outputs.
- R7: Clear addresses on `rd_addr`: 1 RX underflow, 2 RX overflow, 3 TX overflow, 4 abort, 5 activity, 6 stop, 7 start, 8 general call. A strobe clears the addressed bit. One cycle later, `rd_bit` shows the bit's prior value. Addresses 9 to 15 clear nothing and return 0. `rd_bit` is 0 in any cycle that follows no strobe.
- R8: `tx_flush` is high while the abort bit is set. An abort pulse ORs `abort_cause` into `abort_src`. Reading address 4 drops `tx_flush` and zeroes `abort_src`.
- R9: Reading address 0 clears every sticky bit and `abort_src`. Its `rd_bit` is the OR of all sticky bits before the clear.
- R10: While `bus_busy` is high, a clear of the activity bit, whether by address 5 or by address 0, has no effect. The activity bit drops by itself on the cycle after `bus_busy` falls.
- R11: When a set pulse and a clear fall in the same cycle, the bit (and any abort cause) ends up set.
- R12: `abort_src` keeps only these cause positions: 7-bit address NACK 0, 10-bit first byte NACK 1, 10-bit second byte NACK 2, data NACK 3, general call read 4, general call NACK 5, acked START byte 7, START with restart off 9, 10-bit read with restart off 10, arbitration lost 12, user abort 16. All other positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_under | input | 1 | Pulse: RX FIFO read while empty |
| ev_rx_over | input | 1 | Pulse: RX data lost |
| ev_tx_over | input | 1 | Pulse: TX FIFO written while full |
| ev_activity | input | 1 | Pulse: bus activity |
| ev_stop | input | 1 | Pulse: STOP condition seen |
| ev_start | input | 1 | Pulse: START or RESTART seen |
| ev_gen_call | input | 1 | Pulse: general call acknowledged |
| ev_abort | input | 1 | Pulse: transmit abort |
| abort_cause | input | 17 | Cause bits that come with `ev_abort` |
| bus_busy | input | 1 | Bus currently active |
| tx_level | input | 5 | TX FIFO fill level |
| rx_level | input | 5 | RX FIFO fill level |
| tx_thr | input | 8 | Written TX threshold |
| rx_thr | input | 8 | Written RX threshold |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 12 | Mask write value |
| rd_stb | input | 1 | Clear-register read strobe |
| rd_addr | input | 4 | Clear-register address |
| rd_bit | output | 1 | Read return, one cycle after the strobe |
| raw_stat | output | 12 | Raw status |
| masked_stat | output | 12 | Masked status |
| abort_src | output | 17 | Accumulated abort cause |
| tx_flush | output | 1 | Hold TX FIFO flushed |
| irq | output | 1 | Combined interrupt |
| tx_thr_eff | output | 4 | Effective TX threshold |
| rx_thr_eff | output | 4 | Effective RX threshold |

## Verification
The assertions check on every cycle the rules that tie one cycle to the next:
- a set pulse overriding a same-cycle clear;
- a clear taking effect;
- the flush following an abort;
- the cause register emptying after an abort clear;
- the activity bit surviving a clear while the bus is busy and dropping when the bus goes idle;
- the mask holding its value between writes.

Only the bench scenarios can show the following: `rd_bit` returning the value the bit held before the clear, the clamping of large threshold values, the exact level boundaries of the two threshold bits, the filtering of cause positions, and long random mixes of events, reads and mask writes compared against an independent model.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int STAT_W = 12;
  localparam int SRC_W  = 17;

  localparam int B_RX_UNDER = 0;
  localparam int B_RX_OVER  = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_OVER  = 3;
  localparam int B_TX_EMPTY = 4;
  localparam int B_TX_ABRT  = 6;
  localparam int B_ACTIVITY = 8;
  localparam int B_STOP     = 9;
  localparam int B_START    = 10;
  localparam int B_GEN_CALL = 11;

  // sticky (read-to-clear) bits
  localparam logic [STAT_W-1:0] STICKY_BITS = 12'hF4B;
  localparam logic [STAT_W-1:0] MASK_RST    = 12'h8FF;
  // abort cause positions that exist
  localparam logic [SRC_W-1:0]  SRC_VALID   = 17'h116BF;

  typedef enum logic [3:0] {
    CA_ALL      = 4'd0,
    CA_RX_UNDER = 4'd1,
    CA_RX_OVER  = 4'd2,
    CA_TX_OVER  = 4'd3,
    CA_TX_ABRT  = 4'd4,
    CA_ACTIVITY = 4'd5,
    CA_STOP     = 4'd6,
    CA_START    = 4'd7,
    CA_GEN_CALL = 4'd8
  } clr_addr_e;
endpackage

// File: rtl/i2c_irq_thr.sv
module i2c_irq_thr #(
  parameter int DEPTH       = 16,
  parameter int THR_W       = 8,
  parameter bit AT_OR_ABOVE = 1'b0
) (
  input  logic [THR_W-1:0]           thr_i,
  input  logic [$clog2(DEPTH):0]     lvl_i,
  output logic [$clog2(DEPTH)-1:0]   eff_o,
  output logic                       hit_o
);
  localparam int EFF_W = $clog2(DEPTH);
  localparam int LVL_W = EFF_W + 1;
  localparam logic [THR_W-1:0] MAX_T = THR_W'(DEPTH - 1);

  logic [THR_W-1:0] clamped;
  logic [LVL_W-1:0] eff_ext;

  assign clamped = (thr_i > MAX_T) ? MAX_T : thr_i;
  assign eff_o   = clamped[EFF_W-1:0];
  assign eff_ext = {1'b0, eff_o};

  generate
    if (AT_OR_ABOVE) begin : g_ge
      assign hit_o = lvl_i >= (eff_ext + LVL_W'(1));
    end else begin : g_le
      assign hit_o = lvl_i <= eff_ext;
    end
  endgenerate

  always_comb begin
    if (thr_i <= MAX_T)
      assert_clamp_pass_R6: assert (THR_W'(eff_o) == thr_i);
  end
endmodule

// File: rtl/i2c_irq_clr_dec.sv
module i2c_irq_clr_dec
  import i2c_irq_pkg::*;
(
  input  logic              rd_stb,
  input  logic [3:0]        rd_addr,
  input  logic [STAT_W-1:0] state_i,
  output logic [STAT_W-1:0] clr_vec,
  output logic              clr_src,
  output logic              sel_bit
);
  function automatic int addr_bit(input clr_addr_e a);
    case (a)
      CA_RX_UNDER: return B_RX_UNDER;
      CA_RX_OVER:  return B_RX_OVER;
      CA_TX_OVER:  return B_TX_OVER;
      CA_TX_ABRT:  return B_TX_ABRT;
      CA_ACTIVITY: return B_ACTIVITY;
      CA_STOP:     return B_STOP;
      CA_START:    return B_START;
      CA_GEN_CALL: return B_GEN_CALL;
      default:     return -1;
    endcase
  endfunction

  clr_addr_e a_e;
  int        bidx;

  assign a_e  = clr_addr_e'(rd_addr);
  assign bidx = addr_bit(a_e);

  always_comb begin
    clr_vec = '0;
    clr_src = 1'b0;
    sel_bit = 1'b0;
    if (rd_stb) begin
      if (a_e == CA_ALL) begin
        clr_vec = STICKY_BITS;
        clr_src = 1'b1;
        sel_bit = |(state_i & STICKY_BITS);
      end else if (bidx >= 0) begin
        clr_vec[bidx] = 1'b1;
        sel_bit       = state_i[bidx];
        clr_src       = (a_e == CA_TX_ABRT);
      end
    end
  end
endmodule

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky #(
  parameter int         W    = 12,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  generate
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
      if (KEEP[gi]) begin : g_flop
        logic q_r;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q_r <= 1'b0;
          else        q_r <= (q_r & ~clr_i[gi]) | set_i[gi];
        end
        assign q_o[gi] = q_r;

        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
          set_i[gi] |=> q_o[gi]);
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (clr_i[gi] && !set_i[gi]) |=> !q_o[gi]);
      end else begin : g_none
        assign q_o[gi] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int THR_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_rx_under,
  input  logic                          ev_rx_over,
  input  logic                          ev_tx_over,
  input  logic                          ev_activity,
  input  logic                          ev_stop,
  input  logic                          ev_start,
  input  logic                          ev_gen_call,
  input  logic                          ev_abort,
  input  logic [SRC_W-1:0]              abort_cause,
  input  logic                          bus_busy,
  input  logic [$clog2(FIFO_DEPTH):0]   tx_level,
  input  logic [$clog2(FIFO_DEPTH):0]   rx_level,
  input  logic [THR_W-1:0]              tx_thr,
  input  logic [THR_W-1:0]              rx_thr,
  input  logic                          mask_wr,
  input  logic [STAT_W-1:0]             mask_wdata,
  input  logic                          rd_stb,
  input  logic [3:0]                    rd_addr,
  output logic                          rd_bit,
  output logic [STAT_W-1:0]             raw_stat,
  output logic [STAT_W-1:0]             masked_stat,
  output logic [SRC_W-1:0]              abort_src,
  output logic                          tx_flush,
  output logic                          irq,
  output logic [$clog2(FIFO_DEPTH)-1:0] tx_thr_eff,
  output logic [$clog2(FIFO_DEPTH)-1:0] rx_thr_eff
);
  logic [STAT_W-1:0] set_vec, clr_vec, clr_eff, sticky_q;
  logic [STAT_W-1:0] mask_q;
  logic [SRC_W-1:0]  src_q;
  logic              clr_src, sel_bit, rd_q, busy_q;
  logic              tx_hit, rx_hit;

  // event pulses into status positions
  always_comb begin
    set_vec             = '0;
    set_vec[B_RX_UNDER] = ev_rx_under;
    set_vec[B_RX_OVER]  = ev_rx_over;
    set_vec[B_TX_OVER]  = ev_tx_over;
    set_vec[B_TX_ABRT]  = ev_abort;
    set_vec[B_ACTIVITY] = ev_activity;
    set_vec[B_STOP]     = ev_stop;
    set_vec[B_START]    = ev_start;
    set_vec[B_GEN_CALL] = ev_gen_call;
  end

  i2c_irq_clr_dec u_dec (
    .rd_stb  (rd_stb),
    .rd_addr (rd_addr),
    .state_i (sticky_q),
    .clr_vec (clr_vec),
    .clr_src (clr_src),
    .sel_bit (sel_bit)
  );

  // bus-busy history has no reset: it only mirrors the previous input
  always_ff @(posedge clk) busy_q <= bus_busy;

  // activity clears are blocked while busy; it drops when the bus goes idle
  always_comb begin
    clr_eff             = clr_vec;
    clr_eff[B_ACTIVITY] = (clr_vec[B_ACTIVITY] & ~bus_busy) | (busy_q & ~bus_busy);
  end

  i2c_irq_sticky #(.W(STAT_W), .KEEP(STICKY_BITS)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_eff),
    .q_o   (sticky_q)
  );

  i2c_irq_thr #(.DEPTH(FIFO_DEPTH), .THR_W(THR_W), .AT_OR_ABOVE(1'b0)) u_tx_thr (
    .thr_i (tx_thr),
    .lvl_i (tx_level),
    .eff_o (tx_thr_eff),
    .hit_o (tx_hit)
  );

  i2c_irq_thr #(.DEPTH(FIFO_DEPTH), .THR_W(THR_W), .AT_OR_ABOVE(1'b1)) u_rx_thr (
    .thr_i (rx_thr),
    .lvl_i (rx_level),
    .eff_o (rx_thr_eff),
    .hit_o (rx_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      src_q  <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      src_q <= (clr_src ? '0 : src_q) | (ev_abort ? (abort_cause & SRC_VALID) : '0);
      rd_q  <= rd_stb & sel_bit;
    end
  end

  always_comb begin
    raw_stat             = sticky_q;
    raw_stat[B_TX_EMPTY] = tx_hit;
    raw_stat[B_RX_FULL]  = rx_hit;
  end

  assign masked_stat = raw_stat & mask_q;
  assign irq         = |masked_stat;
  assign abort_src   = src_q;
  assign tx_flush    = sticky_q[B_TX_ABRT];
  assign rd_bit      = rd_q;

  assert_flush_after_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> tx_flush);
  assert_src_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == 4'd4 && !ev_abort) |=> (abort_src == '0));
  assert_activity_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == 4'd5 && bus_busy && raw_stat[B_ACTIVITY]) |=> raw_stat[B_ACTIVITY]);
  assert_activity_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bus_busy && !ev_activity) |=> !raw_stat[B_ACTIVITY]);
  assert_mask_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));
endmodule

// File: tb/test_i2c_irq_ctrl.sv
module test_i2c_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_rx_under, ev_rx_over, ev_tx_over, ev_activity;
  logic        ev_stop, ev_start, ev_gen_call, ev_abort;
  logic [16:0] abort_cause;
  logic        bus_busy;
  logic [4:0]  tx_level, rx_level;
  logic [7:0]  tx_thr, rx_thr;
  logic        mask_wr;
  logic [11:0] mask_wdata;
  logic        rd_stb;
  logic [3:0]  rd_addr;
  logic        rd_bit, tx_flush, irq;
  logic [11:0] raw_stat, masked_stat;
  logic [16:0] abort_src;
  logic [3:0]  tx_thr_eff, rx_thr_eff;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  logic [11:0] m_st;
  logic [16:0] m_src;
  logic [11:0] m_mask;
  logic        m_rd, m_busq;

  always #4 clk = ~clk;

  i2c_irq_ctrl i_i2c_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_under(ev_rx_under), .ev_rx_over(ev_rx_over), .ev_tx_over(ev_tx_over),
    .ev_activity(ev_activity), .ev_stop(ev_stop), .ev_start(ev_start),
    .ev_gen_call(ev_gen_call), .ev_abort(ev_abort), .abort_cause(abort_cause),
    .bus_busy(bus_busy), .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_bit(rd_bit), .raw_stat(raw_stat),
    .masked_stat(masked_stat), .abort_src(abort_src), .tx_flush(tx_flush),
    .irq(irq), .tx_thr_eff(tx_thr_eff), .rx_thr_eff(rx_thr_eff)
  );

  function automatic logic [3:0] clampf(input logic [7:0] v);
    return (v > 8'd15) ? 4'd15 : v[3:0];
  endfunction

  function automatic logic [11:0] exp_raw();
    logic [11:0] r;
    r = m_st;
    r[4] = ({1'b0, tx_level} <= {2'b0, clampf(tx_thr)});
    r[2] = ({1'b0, rx_level} >= ({2'b0, clampf(rx_thr)} + 6'd1));
    return r;
  endfunction

  function automatic int bit_of(input logic [3:0] a);
    case (a)
      4'd1: return 0;  4'd2: return 1;  4'd3: return 3;  4'd4: return 6;
      4'd5: return 8;  4'd6: return 9;  4'd7: return 10; 4'd8: return 11;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [11:0] r;
    r = exp_raw();
    chk("R1 raw_stat", 32'(raw_stat), 32'(r));
    chk("R2 masked_stat", 32'(masked_stat), 32'(r & m_mask));
    chk("R3 irq", 32'(irq), 32'(|(r & m_mask)));
    chk("R12 abort_src", 32'(abort_src), 32'(m_src));
    chk("R8 tx_flush", 32'(tx_flush), 32'(m_st[6]));
    chk("R7 rd_bit", 32'(rd_bit), 32'(m_rd));
    chk("R6 thr_eff", 32'({tx_thr_eff, rx_thr_eff}), 32'({clampf(tx_thr), clampf(rx_thr)}));
  endtask

  task automatic idle();
    ev_rx_under = 0; ev_rx_over = 0; ev_tx_over = 0; ev_activity = 0;
    ev_stop = 0; ev_start = 0; ev_gen_call = 0; ev_abort = 0;
    abort_cause = '0; mask_wr = 0; mask_wdata = '0; rd_stb = 0; rd_addr = '0;
  endtask

  // advance one clock with the inputs already driven; update model, check
  task automatic step();
    logic [11:0] sv, cv, nst;
    logic [16:0] nsrc;
    logic        nrd;
    int          b;
    sv = '0;
    sv[0] = ev_rx_under; sv[1] = ev_rx_over; sv[3] = ev_tx_over; sv[6] = ev_abort;
    sv[8] = ev_activity; sv[9] = ev_stop; sv[10] = ev_start; sv[11] = ev_gen_call;
    cv = '0; nrd = 1'b0;
    b = bit_of(rd_addr);
    if (rd_stb) begin
      if (rd_addr == 4'd0) begin cv = 12'hF4B; nrd = |m_st; end
      else if (b >= 0) begin cv[b] = 1'b1; nrd = m_st[b]; end
    end
    if (bus_busy) cv[8] = 1'b0;
    if (m_busq && !bus_busy) cv[8] = 1'b1;
    nst  = (m_st & ~cv) | sv;
    nsrc = ((rd_stb && (rd_addr == 4'd0 || rd_addr == 4'd4)) ? 17'h0 : m_src)
           | (ev_abort ? (abort_cause & 17'h116BF) : 17'h0);
    @(posedge clk);
    @(negedge clk);
    m_st = nst; m_src = nsrc; m_rd = nrd; m_busq = bus_busy;
    if (mask_wr) m_mask = mask_wdata;
    check_all();
    idle();
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    bus_busy = 0; tx_level = 0; rx_level = 0; tx_thr = 0; rx_thr = 0;
    m_st = '0; m_src = '0; m_mask = 12'h8FF; m_rd = 0; m_busq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: only the TX level bit (R4) is up, mask 0x8FF (R2)
    chk("R2 reset masked", 32'(masked_stat), 32'h010);
    chk("R1 reset raw", 32'(raw_stat), 32'h010);
    check_all();

    // R6 clamp with R4/R5 boundaries
    tx_thr = 8'd200; rx_thr = 8'd99; tx_level = 5'd15; rx_level = 5'd15; step();
    chk("R6 tx clamp", 32'(tx_thr_eff), 32'd15);
    chk("R4 tx at thr", 32'(raw_stat[4]), 32'd1);
    chk("R5 rx below", 32'(raw_stat[2]), 32'd0);
    tx_level = 5'd16; rx_level = 5'd16; step();
    chk("R4 tx above", 32'(raw_stat[4]), 32'd0);
    chk("R5 rx at thr+1", 32'(raw_stat[2]), 32'd1);
    tx_thr = 8'd3; rx_thr = 8'd3; tx_level = 5'd3; rx_level = 5'd3; step();

    // R8/R12 abort then acknowledge
    ev_abort = 1; abort_cause = 17'h1FFFF; step();
    chk("R12 cause filter", 32'(abort_src), 32'h116BF);
    chk("R8 flush set", 32'(tx_flush), 32'd1);
    rd_stb = 1; rd_addr = 4'd4; step();
    chk("R7 abort rd", 32'(rd_bit), 32'd1);
    chk("R8 flush released", 32'(tx_flush), 32'd0);
    chk("R8 src cleared", 32'(abort_src), 32'd0);

    // R11 set and clear in one cycle
    ev_stop = 1; step();
    ev_stop = 1; rd_stb = 1; rd_addr = 4'd6; step();
    chk("R11 set wins", 32'(raw_stat[9]), 32'd1);
    rd_stb = 1; rd_addr = 4'd12; step();
    chk("R7 unused addr", 32'({rd_bit, raw_stat[9]}), 32'd1);

    // R10 activity clear blocked while busy, drops on idle
    bus_busy = 1; ev_activity = 1; step();
    bus_busy = 1; rd_stb = 1; rd_addr = 4'd5; step();
    chk("R10 held while busy", 32'(raw_stat[8]), 32'd1);
    bus_busy = 0; step();
    chk("R10 auto drop", 32'(raw_stat[8]), 32'd0);

    // R9 global clear, R3 mask off
    ev_start = 1; ev_gen_call = 1; ev_tx_over = 1; ev_abort = 1; abort_cause = 17'h00001; step();
    rd_stb = 1; rd_addr = 4'd0; step();
    chk("R9 global clear", 32'(raw_stat & 12'hF4B), 32'd0);
    chk("R9 global rd", 32'(rd_bit), 32'd1);
    mask_wr = 1; mask_wdata = 12'h000; step();
    chk("R3 irq masked off", 32'(irq), 32'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      ev_rx_under = ($urandom_range(0, 7) == 0);
      ev_rx_over  = ($urandom_range(0, 7) == 0);
      ev_tx_over  = ($urandom_range(0, 7) == 0);
      ev_activity = ($urandom_range(0, 5) == 0);
      ev_stop     = ($urandom_range(0, 7) == 0);
      ev_start    = ($urandom_range(0, 7) == 0);
      ev_gen_call = ($urandom_range(0, 9) == 0);
      ev_abort    = ($urandom_range(0, 9) == 0);
      abort_cause = 17'($urandom());
      if ($urandom_range(0, 3) == 0) bus_busy = ~bus_busy;
      tx_level = 5'($urandom_range(0, 16));
      rx_level = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 15) == 0) tx_thr = 8'($urandom());
      if ($urandom_range(0, 15) == 0) rx_thr = 8'($urandom_range(0, 20));
      mask_wr    = ($urandom_range(0, 19) == 0);
      mask_wdata = 12'($urandom());
      rd_stb     = ($urandom_range(0, 2) == 0);
      rd_addr    = 4'($urandom_range(0, 10));
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule